// File: doc/BRIEF.md
# Non-volatile Memory Shadow Sequencer

This block moves bytes between a byte-wide non-volatile memory and a 256-entry volatile shadow array. The array holds the working copy that the rest of the chip reads and writes. A single 16-bit control word selects the work. A full load copies every stored byte into the shadow array. A single-byte cycle either reads one byte in or writes one shadow byte out. An upload reloads the whole array without touching the checksum result.

Each full load ends with an integrity check. The block sums a fixed window of low bytes, keeps the low eight bits, and compares them with a reference byte that sits just above that window. It reports both the computed sum and a match flag. The memory side uses a plain request/acknowledge handshake, one byte per acknowledge. A full load starts by itself as soon as reset is released.

Top module: `nvr_shadow_ctrl`

## Requirements
- R1: While reset is held, and from its release on, the block is busy and requests memory address 0 for reading, so a full load begins without any command.
- R2: A control word with bits 1:0 = 00 and bit 5 = 0 loads memory bytes 0 to 255 into the matching shadow entries. It makes exactly 256 transfers in ascending address order and holds each address until that byte is acknowledged.
- R3: When a full load completes, `csum_calc` holds the low 8 bits of the sum of bytes 0 to 117, and `csum_ok` is 1 exactly when that value equals byte 118.
- R4: A control word with bits 1:0 = 10 and bit 5 = 0 reads the memory byte at the address in bits 15:8 into that shadow entry. It makes one transfer and leaves other entries unchanged.
- R5: A control word with bits 1:0 = 10 and bit 5 = 1 writes the shadow entry at the address in bits 15:8 to that memory address. It makes one transfer, and no other command ever drives a memory write.
- R6: A control word with bits 1:0 = 11 and bit 5 = 0 reloads all 256 shadow entries from memory and leaves `csum_calc` and `csum_ok` unchanged.
- R7: Any other control word starts no transfer and leaves the control readback unchanged. These are bits 1:0 = 01, or bit 5 = 1 together with bits 1:0 = 00 or 11.
- R8: While busy, control writes and host shadow writes are ignored.
- R9: A host shadow write while idle changes only that entry and causes no memory transfer.
- R10: `busy` rises on the edge that accepts a command and falls on the edge of the final acknowledge. At that same edge `done` rises. `done` stays high until the next accepted command, and `mem_req` is only high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release starts a full load |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: bits 1:0 operation, bit 5 direction, bits 15:8 byte address |
| ctl_rdata | output | 16 | Last accepted control word |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Transfer complete; read data valid |
| mem_rdata | input | 8 | Byte read from memory |
| sh_we | input | 1 | Host shadow write strobe |
| sh_addr | input | 8 | Host shadow address |
| sh_wdata | input | 8 | Host shadow write data |
| sh_rdata | output | 8 | Shadow entry at `sh_addr` |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Last cycle completed |
| csum_calc | output | 8 | Checksum computed by the last full load |
| csum_ok | output | 1 | Computed checksum matched byte 118 |

## Verification
The bench builds the block with its defaults: an 8-bit address, so 256 entries, the sum ending at byte 117 and the reference at byte 118. With these values a full walk is short enough to repeat several times. The extreme address 255 and address 0 are both reachable by single-byte cycles. The reference byte lies inside the loaded range but outside the summed window, so corrupting it shows a mismatch without changing the computed sum. A reset asserted during an upload shows that the automatic load restarts from address 0.

// File: rtl/nvr_shadow_ctrl.sv
module nvr_shadow_ctrl #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int CSUM_LAST = 117,
  parameter int CSUM_REF  = 118
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [15:0]   ctl_wdata,
  output logic [15:0]   ctl_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          sh_we,
  input  logic [AW-1:0] sh_addr,
  input  logic [DW-1:0] sh_wdata,
  output logic [DW-1:0] sh_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] csum_calc,
  output logic          csum_ok
);

  localparam int            DEPTH   = 1 << AW;
  localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] SUM_END = AW'(CSUM_LAST);
  localparam logic [AW-1:0] REF_A   = AW'(CSUM_REF);

  typedef enum logic [1:0] {S_IDLE, S_BULK, S_ONE} state_t;

  state_t        st;
  logic [15:0]   ctl_q;
  logic [AW-1:0] ptr;
  logic [DW-1:0] acc;
  logic          req_q;
  logic          bulk_sum;
  logic [DW-1:0] shadow [DEPTH];

  wire cmd_full = (ctl_wdata[1:0] == 2'b00) && !ctl_wdata[5];
  wire cmd_one  = (ctl_wdata[1:0] == 2'b10);
  wire cmd_up   = (ctl_wdata[1:0] == 2'b11) && !ctl_wdata[5];
  wire accept   = ctl_we && (st == S_IDLE) && (cmd_full || cmd_one || cmd_up);
  wire xfer     = req_q && mem_ack;
  wire one_wr   = (st == S_ONE) && ctl_q[5];

  logic [DW-1:0] acc_nx;
  logic [DW-1:0] ref_byte;
  assign acc_nx   = (ptr <= SUM_END) ? acc + mem_rdata : acc;
  assign ref_byte = (ptr == REF_A) ? mem_rdata : shadow[REF_A];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_BULK;
      req_q     <= 1'b1;
      ptr       <= '0;
      acc       <= '0;
      bulk_sum  <= 1'b1;
      ctl_q     <= '0;
      done      <= 1'b0;
      csum_calc <= '0;
      csum_ok   <= 1'b0;
    end else if (accept) begin
      ctl_q    <= ctl_wdata;
      done     <= 1'b0;
      req_q    <= 1'b1;
      acc      <= '0;
      bulk_sum <= cmd_full;
      if (cmd_one) begin
        st  <= S_ONE;
        ptr <= ctl_wdata[8 +: AW];
      end else begin
        st  <= S_BULK;
        ptr <= '0;
      end
    end else if (xfer) begin
      if (st == S_BULK) begin
        acc <= acc_nx;
        if (ptr == LAST_A) begin
          st    <= S_IDLE;
          req_q <= 1'b0;
          done  <= 1'b1;
          if (bulk_sum) begin
            csum_calc <= acc_nx;
            csum_ok   <= (acc_nx == ref_byte);
          end
        end else begin
          ptr <= ptr + 1'b1;
        end
      end else begin
        st    <= S_IDLE;
        req_q <= 1'b0;
        done  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (xfer && (st != S_IDLE) && !one_wr)
      shadow[ptr] <= mem_rdata;
    else if (sh_we && (st == S_IDLE))
      shadow[sh_addr] <= sh_wdata;
  end

  assign busy      = (st != S_IDLE);
  assign mem_req   = req_q;
  assign mem_we    = one_wr;
  assign mem_addr  = ptr;
  assign mem_wdata = shadow[ptr];
  assign sh_rdata  = shadow[sh_addr];
  assign ctl_rdata = ctl_q;

endmodule

// File: rtl/nvr_shadow_ctrl_chk.sv
module nvr_shadow_ctrl_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [15:0]   ctl_wdata,
  input logic [15:0]   ctl_rdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] csum_calc,
  input logic          csum_ok
);

  assert_req_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_write_single_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (ctl_rdata[1:0] == 2'b10) && ctl_rdata[5]);

  assert_ctl_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_we |=> $stable(ctl_rdata));

  assert_upload_keeps_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (ctl_rdata[1:0] == 2'b11) |=> $stable(csum_calc) && $stable(csum_ok));

  assert_bad_code_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ctl_we && ((ctl_wdata[1:0] == 2'b01) || (ctl_wdata[5] && (ctl_wdata[1:0] != 2'b10)))
    |=> !busy && $stable(ctl_rdata));

endmodule

bind nvr_shadow_ctrl nvr_shadow_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .busy(busy), .done(done), .csum_calc(csum_calc), .csum_ok(csum_ok)
);

// File: tb/nvr_shadow_ctrl_bench.sv
module nvr_shadow_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [7:0]  mem_addr, mem_wdata, mem_rdata;
  logic        sh_we = 1'b0;
  logic [7:0]  sh_addr = '0, sh_wdata = '0, sh_rdata;
  logic        busy, done, csum_ok;
  logic [7:0]  csum_calc;

  nvr_shadow_ctrl u_nvr_shadow_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .sh_we(sh_we), .sh_addr(sh_addr),
    .sh_wdata(sh_wdata), .sh_rdata(sh_rdata), .busy(busy), .done(done),
    .csum_calc(csum_calc), .csum_ok(csum_ok)
  );

  logic [7:0] nv [256];
  int acks = 0;
  int wrs  = 0;

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= nv[mem_addr];
        if (mem_we) begin
          nv[mem_addr] <= mem_wdata;
          wrs <= wrs + 1;
        end
      end
      if (mem_req && mem_ack) acks <= acks + 1;
    end
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sum();
    logic [7:0] s = '0;
    for (int i = 0; i <= 117; i++) s = s + nv[i];
    return s;
  endfunction

  task automatic nv_set(input logic [7:0] a, input logic [7:0] v);
    nv[a] <= v;
    #1;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    sh_addr = a;
    #1 v = sh_rdata;
  endtask

  task automatic sh_write(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    sh_we = 1'b1; sh_addr = a; sh_wdata = v;
    @(negedge clk);
    sh_we = 1'b0;
  endtask

  task automatic issue(input logic [15:0] c);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = c;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    check(!busy && done, req, {busy, done}, 2'b01);
  endtask

  task automatic full_compare(input string req);
    int bad = 0;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      peek(8'(i), v);
      if (v !== nv[i]) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  // {control word, kind}: 0 ignored, 1 full load, 2 single read, 3 single write, 4 upload
  localparam logic [18:0] VEC [10] = '{
    {16'h0000, 3'd1}, {16'h2A02, 3'd2}, {16'h4022, 3'd3}, {16'h0003, 3'd4},
    {16'h0001, 3'd0}, {16'h0020, 3'd0}, {16'h0023, 3'd0}, {16'hFF02, 3'd2},
    {16'h0022, 3'd3}, {16'h8021, 3'd0}
  };

  initial begin
    #(2_000_000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v, nb, c0;
    logic ok0;
    logic [15:0] ctl0;
    int a0, w0;

    for (int i = 0; i < 256; i++) nv[i] <= 8'(i * 13 + 5);
    #1;
    nv_set(8'd118, exp_sum());
    repeat (3) @(negedge clk);
    check(busy && mem_req && !mem_we && mem_addr == 0, "R1 reset state", {busy, mem_req, mem_we}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy && mem_req && mem_addr == 0 && !done, "R1 auto load start", {busy, mem_req, mem_addr}, {2'b11, 8'h00});
    wait_idle("R1 auto load ends");
    check(acks == 256, "R2 transfer count", acks, 256);
    full_compare("R2 shadow contents");
    check(csum_calc == exp_sum() && csum_ok, "R3 checksum match", {csum_ok, csum_calc}, {1'b1, exp_sum()});

    for (int i = 0; i < 10; i++) begin
      logic [15:0] cmd = VEC[i][18:3];
      logic [2:0]  knd = VEC[i][2:0];
      logic [7:0]  a   = cmd[15:8];
      v = 8'hA0 + 8'(i);
      case (knd)
        3'd1: begin nv_set(8'd7, v); nv_set(8'd118, exp_sum()); end
        3'd2: nv_set(a, v);
        3'd3: sh_write(a, v);
        3'd4: begin nv_set(8'd7, v); nv_set(8'd118, nv[118] + 8'd1); end
        default: ;
      endcase
      @(negedge clk);
      peek(a ^ 8'h01, nb);
      c0 = csum_calc; ok0 = csum_ok; ctl0 = ctl_rdata; a0 = acks; w0 = wrs;
      issue(cmd);
      if (knd == 3'd0) begin
        repeat (4) @(negedge clk);
        check(!busy && ctl_rdata == ctl0 && acks == a0, "R7 ignored code", {ctl_rdata, 8'(acks - a0)}, {ctl0, 8'h00});
      end else begin
        check(busy && !done, "R10 busy on accept", {busy, done}, 2'b10);
        wait_idle("R10 done on completion");
        check(ctl_rdata == cmd, "R10 control readback", ctl_rdata, cmd);
        case (knd)
          3'd1: begin
            peek(8'd7, v);
            check(v == nv[7] && acks - a0 == 256, "R2 full load", {v, 8'(acks - a0)}, {nv[7], 8'h00});
            check(csum_calc == exp_sum() && csum_ok, "R3 checksum after load", {csum_ok, csum_calc}, {1'b1, exp_sum()});
          end
          3'd2: begin
            peek(a, v);
            check(v == nv[a] && acks - a0 == 1, "R4 single read", {v, 8'(acks - a0)}, {nv[a], 8'h01});
            peek(a ^ 8'h01, v);
            check(v == nb, "R4 neighbour untouched", v, nb);
          end
          3'd3: begin
            check(nv[a] == 8'hA0 + 8'(i) && wrs - w0 == 1 && acks - a0 == 1, "R5 single write",
                  {nv[a], 8'(wrs - w0)}, {8'hA0 + 8'(i), 8'h01});
          end
          default: begin
            peek(8'd7, v);
            check(v == nv[7] && acks - a0 == 256, "R6 upload reloads", v, nv[7]);
            check(csum_calc == c0 && csum_ok == ok0, "R6 checksum kept", {csum_ok, csum_calc}, {ok0, c0});
          end
        endcase
      end
    end

    // R3 mismatch: corrupted reference byte
    nv_set(8'd118, exp_sum() ^ 8'h5A);
    issue(16'h0000);
    wait_idle("R3 load with bad reference");
    check(csum_calc == exp_sum() && !csum_ok, "R3 checksum mismatch", {csum_ok, csum_calc}, {1'b0, exp_sum()});

    // R8: writes during a busy single read are dropped
    peek(8'd20, nb);
    nv_set(8'd10, 8'h3C);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 16'h0A02;
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 16'h3302;
    sh_we = 1'b1; sh_addr = 8'd20; sh_wdata = ~nb;
    @(negedge clk);
    ctl_we = 1'b0; sh_we = 1'b0;
    wait_idle("R8 single read completes");
    check(ctl_rdata == 16'h0A02, "R8 control write ignored", ctl_rdata, 16'h0A02);
    peek(8'd20, v);
    check(v == nb, "R8 shadow write ignored", v, nb);

    // R9: idle host write makes no memory transfer
    a0 = acks;
    sh_write(8'd200, 8'hC3);
    repeat (3) @(negedge clk);
    peek(8'd200, v);
    check(v == 8'hC3 && acks == a0 && !busy, "R9 idle shadow write", {v, 8'(acks - a0)}, {8'hC3, 8'h00});

    // R10: done clears when next command is accepted
    issue(16'h0502);
    check(!done && busy, "R10 done cleared", {done, busy}, 2'b01);
    wait_idle("R10 second completion");

    // R1: reset during an upload restarts the load
    issue(16'h0003);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy && mem_addr == 0 && !done && ctl_rdata == 16'h0000, "R1 restart after reset",
          {busy, mem_addr, done}, {1'b1, 8'h00, 1'b0});
    wait_idle("R1 restarted load ends");
    check(csum_calc == exp_sum() && csum_ok == (exp_sum() == nv[118]), "R3 checksum after restart",
          {csum_ok, csum_calc}, {exp_sum() == nv[118], exp_sum()});

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule